// File: doc/BRIEF.md
# Autobaud 8N1 Serial Receiver

This receiver listens on one shared serial line whose rate is set entirely by the remote master. It has no baud configuration. Instead it times the falling edges of a 0x55 sync character sent at the start of each packet and derives the bit period, in system clocks, from that character. Once the period is known it raises a locked flag and receives ordinary 8N1 frames: one start bit, eight data bits sent least significant first, one stop bit and no parity. Each good byte appears as a one-cycle strobe with its data.

The measured period is driven out so that a companion transmitter can answer at the same rate. A new measurement is started on an explicit request, when the block is disabled, or when a framing error is followed by a stretch of idle line. The line input passes through a two-flop synchronizer before any edge detection, and the line is taken to idle high.

Top module: `autobaud_rx`

## Requirements
- R1: After a 0x55 sync character sent with a bit period of P clocks (P at least 4), locked_o is 1 and period_o equals P by the end of that character's stop bit. period_o does not change while locked_o stays high.
- R2: The sync character is not delivered as data: rx_valid_o does not pulse while it is received.
- R3: While locked, each frame whose stop bit is high produces exactly one single-cycle rx_valid_o pulse, with rx_data_o holding the eight data bits in arrival order, first bit in bit 0.
- R4: A sync character whose measured period is below 4 clocks leaves locked_o at 0.
- R5: If the fourth falling edge after the first does not arrive before the measurement counter (CNT_W+3 bits) saturates, the measurement is abandoned, locked_o stays 0, and a later good sync character still locks.
- R6: A frame whose stop bit is sampled low sets frame_err_o to 1 and produces no rx_valid_o pulse for that byte.
- R7: Once frame_err_o is set, if the line then stays high for IDLE_BITS bit periods (default 10), locked_o and frame_err_o return to 0 and the receiver hunts for a new sync character.
- R8: A relock_i pulse makes locked_o 0 on the next cycle, and the next sync character sets a new period.
- R9: While en_i is 0, locked_o is 0 on the cycle after, the line is ignored, and no sync is measured.
- R10: During and right after reset, locked_o, rx_valid_o, frame_err_o and period_o are 0.
- R11: rx_valid_o is only ever high while locked_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Receiver enable; low forces unlocked |
| relock_i | input | 1 | Request to drop lock and re-measure |
| line_i | input | 1 | Raw serial line, idles high |
| rx_valid_o | output | 1 | One-cycle strobe for a good byte |
| rx_data_o | output | 8 | Received byte |
| locked_o | output | 1 | Bit period has been measured |
| frame_err_o | output | 1 | Stop bit was sampled low |
| period_o | output | CNT_W | Measured bit period in clocks |

## Verification
The hardest state to reach from the ports is the overflow abort of the measurement. It needs a first falling edge followed by more than 2^(CNT_W+3) clocks without the remaining sync edges. The bench therefore builds the receiver with a narrow counter and holds the line low long enough to saturate it. It then shows that a normal sync still locks. The recovery after a framing error is also reached on purpose: a table entry drives a low stop bit, and the bench then holds the line idle for more than IDLE_BITS periods before it looks at the flags.

// File: rtl/autobaud_pkg.sv
package autobaud_pkg;
  localparam int DATA_BITS  = 8;
  localparam int SYNC_FALLS = 4;  // falls after the first one within 0x55
  localparam int SYNC_SHIFT = 3;  // span of those falls is 8 bit periods

  typedef enum logic [1:0] {M_HUNT, M_COUNT, M_LOCK} meas_st_e;
  typedef enum logic [2:0] {F_IDLE, F_START, F_DATA, F_STOP, F_ERR} frame_st_e;
endpackage

// File: rtl/ab_sync.sv
module ab_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= 1'b1;
    else         chain_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= 1'b1;
      else         chain_q[g] <= chain_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= chain_q[STAGES-1];
  end

  assign q_o    = chain_q[STAGES-1];
  assign fall_o = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/ab_meas.sv
module ab_meas
  import autobaud_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int MIN_PERIOD = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             fall_i,
  output logic             locked_o,
  output logic [CNT_W-1:0] period_o
);
  localparam int TOT_W  = CNT_W + SYNC_SHIFT;
  localparam int FALL_W = $clog2(SYNC_FALLS);

  meas_st_e          st_q;
  logic [TOT_W-1:0]  tot_q;
  logic [FALL_W-1:0] falls_q;
  logic [CNT_W-1:0]  cand;

  assign cand = tot_q[TOT_W-1:SYNC_SHIFT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= M_HUNT;
      tot_q    <= '0;
      falls_q  <= '0;
      locked_o <= 1'b0;
      period_o <= '0;
    end else if (clear_i) begin
      st_q     <= M_HUNT;
      tot_q    <= '0;
      falls_q  <= '0;
      locked_o <= 1'b0;
    end else begin
      unique case (st_q)
        M_HUNT: if (fall_i) begin
          tot_q   <= TOT_W'(1);
          falls_q <= '0;
          st_q    <= M_COUNT;
        end
        M_COUNT: begin
          if (&tot_q) begin
            st_q <= M_HUNT;  // saturated: give up on this attempt
          end else begin
            tot_q <= tot_q + 1'b1;
            if (fall_i) begin
              if (falls_q == FALL_W'(SYNC_FALLS - 1)) begin
                if (cand >= CNT_W'(MIN_PERIOD)) begin
                  locked_o <= 1'b1;
                  period_o <= cand;
                  st_q     <= M_LOCK;
                end else begin
                  st_q <= M_HUNT;
                end
              end else begin
                falls_q <= falls_q + 1'b1;
              end
            end
          end
        end
        M_LOCK: st_q <= M_LOCK;
        default: st_q <= M_HUNT;
      endcase
    end
  end

  p_min_period_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> (period_o >= CNT_W'(MIN_PERIOD)));

  p_period_stable_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && $past(locked_o)) |-> $stable(period_o));
endmodule

// File: rtl/ab_frame.sv
module ab_frame
  import autobaud_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int IDLE_BITS = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             line_i,
  input  logic             fall_i,
  output logic             valid_o,
  output logic [7:0]       data_o,
  output logic             err_o,
  output logic             unlock_o
);
  localparam int BN_MAX = (IDLE_BITS > DATA_BITS) ? IDLE_BITS : DATA_BITS;
  localparam int BN_W   = $clog2(BN_MAX + 1);

  frame_st_e        st_q;
  logic [CNT_W-1:0] tmr_q;
  logic [BN_W-1:0]  bitn_q;
  logic [7:0]       sh_q;
  logic             tick;

  assign tick     = (tmr_q == '0);
  assign unlock_o = (st_q == F_ERR) && (bitn_q == BN_W'(IDLE_BITS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= F_IDLE;
      tmr_q   <= '0;
      bitn_q  <= '0;
      sh_q    <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (!run_i) begin
        st_q   <= F_IDLE;
        bitn_q <= '0;
        err_o  <= 1'b0;
      end else begin
        unique case (st_q)
          F_IDLE: if (fall_i) begin
            tmr_q <= period_i >> 1;  // aim at the middle of the start bit
            st_q  <= F_START;
          end
          F_START: begin
            if (tick) begin
              tmr_q  <= period_i - 1'b1;
              bitn_q <= '0;
              st_q   <= F_DATA;
            end else tmr_q <= tmr_q - 1'b1;
          end
          F_DATA: begin
            if (tick) begin
              sh_q  <= {line_i, sh_q[7:1]};
              tmr_q <= period_i - 1'b1;
              if (bitn_q == BN_W'(DATA_BITS - 1)) st_q <= F_STOP;
              else bitn_q <= bitn_q + 1'b1;
            end else tmr_q <= tmr_q - 1'b1;
          end
          F_STOP: begin
            if (tick) begin
              if (line_i) begin
                valid_o <= 1'b1;
                data_o  <= sh_q;
                st_q    <= F_IDLE;
              end else begin
                err_o  <= 1'b1;
                tmr_q  <= period_i - 1'b1;
                bitn_q <= '0;
                st_q   <= F_ERR;
              end
            end else tmr_q <= tmr_q - 1'b1;
          end
          F_ERR: begin
            if (!line_i) begin
              tmr_q  <= period_i - 1'b1;
              bitn_q <= '0;
            end else if (tick) begin
              tmr_q <= period_i - 1'b1;
              if (bitn_q != BN_W'(IDLE_BITS)) bitn_q <= bitn_q + 1'b1;
            end else tmr_q <= tmr_q - 1'b1;
          end
          default: st_q <= F_IDLE;
        endcase
      end
    end
  end

  p_valid_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_err_novalid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !valid_o);
endmodule

// File: rtl/autobaud_rx.sv
module autobaud_rx #(
  parameter int CNT_W       = 16,
  parameter int MIN_PERIOD  = 4,
  parameter int IDLE_BITS   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             relock_i,
  input  logic             line_i,
  output logic             rx_valid_o,
  output logic [7:0]       rx_data_o,
  output logic             locked_o,
  output logic             frame_err_o,
  output logic [CNT_W-1:0] period_o
);
  logic line_s, fall_s, unlock, clear, run;

  assign clear = relock_i | ~en_i | unlock;
  assign run   = locked_o & ~clear;

  ab_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (line_i),
    .q_o    (line_s),
    .fall_o (fall_s)
  );

  ab_meas #(.CNT_W(CNT_W), .MIN_PERIOD(MIN_PERIOD)) u_meas (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear),
    .fall_i   (fall_s),
    .locked_o (locked_o),
    .period_o (period_o)
  );

  ab_frame #(.CNT_W(CNT_W), .IDLE_BITS(IDLE_BITS)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .period_i (period_o),
    .line_i   (line_s),
    .fall_i   (fall_s),
    .valid_o  (rx_valid_o),
    .data_o   (rx_data_o),
    .err_o    (frame_err_o),
    .unlock_o (unlock)
  );

  p_valid_locked_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> locked_o);

  p_relock_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    relock_i |=> !locked_o);

  p_disable_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !locked_o);
endmodule

// File: tb/autobaud_rx_bench.sv
module autobaud_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW         = 8;
  localparam int IDLE_B     = 10;

  typedef struct packed {
    logic [15:0] per;
    logic [7:0]  data;
    logic        stop_ok;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{16'd16,  8'hA3, 1'b1},
    '{16'd16,  8'h00, 1'b1},
    '{16'd23,  8'hFF, 1'b1},
    '{16'd4,   8'h5A, 1'b1},
    '{16'd37,  8'h81, 1'b1},
    '{16'd9,   8'h55, 1'b1},
    '{16'd16,  8'h3C, 1'b0},
    '{16'd50,  8'h7E, 1'b1},
    '{16'd200, 8'hC6, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b1, relock = 1'b0, line = 1'b1;
  logic          rx_valid, locked, frame_err;
  logic [7:0]    rx_data;
  logic [CW-1:0] period;

  int total = 0, bad = 0, nval = 0;
  logic [7:0] last_data = '0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  autobaud_rx #(.CNT_W(CW), .IDLE_BITS(IDLE_B)) u_autobaud_rx (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .relock_i(relock), .line_i(line),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data), .locked_o(locked),
    .frame_err_o(frame_err), .period_o(period)
  );

  always @(negedge clk) if (rx_valid) begin
    nval++;
    last_data = rx_data;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input int per, input logic [7:0] d, input logic stop_v);
    line = 1'b0; idle(per);
    for (int i = 0; i < 8; i++) begin
      line = d[i]; idle(per);
    end
    line = stop_v; idle(per);
    line = 1'b1;
  endtask

  task automatic pulse_relock();
    relock = 1'b1; idle(1);
    relock = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int nv0;
    // R10 reset values
    idle(3);
    check(!locked && !rx_valid && !frame_err && period == 0, "R10 in reset",
          int'(locked), 0);
    rst_n = 1'b1; idle(3);
    check(!locked && !frame_err && period == 0, "R10 after reset", int'(period), 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      int p = int'(VEC[v].per);
      pulse_relock(); idle(4);
      nv0 = nval;
      send_byte(p, 8'h55, 1'b1);
      idle(2);
      check(locked, "R1 locked after sync", int'(locked), 1);
      check(int'(period) == p, "R1 period", int'(period), p);
      check(nval == nv0, "R2 sync not delivered", nval - nv0, 0);
      idle(2);
      nv0 = nval;
      send_byte(p, VEC[v].data, VEC[v].stop_ok);
      idle(3);
      if (VEC[v].stop_ok) begin
        check(nval == nv0 + 1, "R3 one strobe", nval - nv0, 1);
        check(last_data == VEC[v].data, "R3 data", int'(last_data), int'(VEC[v].data));
        check(!frame_err, "R3 no error", int'(frame_err), 0);
      end else begin
        check(frame_err, "R6 error flag", int'(frame_err), 1);
        check(nval == nv0, "R6 no strobe", nval - nv0, 0);
        idle((IDLE_B + 2) * p);
        check(!locked, "R7 unlocked after idle", int'(locked), 0);
        check(!frame_err, "R7 error cleared", int'(frame_err), 0);
        send_byte(p, 8'h55, 1'b1); idle(2);
        check(locked && int'(period) == p, "R7 relocks", int'(period), p);
      end
    end

    // R4 period too short
    pulse_relock(); idle(4);
    send_byte(3, 8'h55, 1'b1); idle(4);
    check(!locked, "R4 short period rejected", int'(locked), 0);

    // R5 counter overflow abandons measurement
    pulse_relock(); idle(4);
    line = 1'b0; idle(3000); line = 1'b1; idle(10);
    check(!locked, "R5 overflow unlocked", int'(locked), 0);
    send_byte(16, 8'h55, 1'b1); idle(2);
    check(locked && period == 16, "R5 locks after overflow", int'(period), 16);

    // R8 relock request
    idle(1);
    pulse_relock();
    check(!locked, "R8 relock drops lock", int'(locked), 0);
    idle(4);
    send_byte(12, 8'h55, 1'b1); idle(2);
    check(locked && period == 12, "R8 new period", int'(period), 12);

    // R9 disable
    en = 1'b0; idle(1);
    check(!locked, "R9 disable drops lock", int'(locked), 0);
    nv0 = nval;
    send_byte(16, 8'h55, 1'b1); idle(2);
    send_byte(16, 8'h12, 1'b1); idle(2);
    check(!locked, "R9 sync ignored while disabled", int'(locked), 0);
    check(nval == nv0, "R9 no strobe while disabled", nval - nv0, 0);
    en = 1'b1; idle(4);
    send_byte(20, 8'h55, 1'b1); idle(2);
    check(locked && period == 20, "R9 locks after enable", int'(period), 20);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule